// File: doc/BRIEF.md
# Linear Flash Read Sequencer

This block lets a processor read serial NOR flash as if it were plain memory. A word read into the linear window is answered from a one-line buffer when the line is already held. Otherwise the sequencer first refills the line. A refill aligns the request to the line size and turns that into a flash byte address. It then drives a complete read command, one byte at a time, into an external byte-level serial engine. The command is the opcode, three address bytes, an optional mode byte, a number of zero dummy bytes and one zero clock byte per data byte. The bytes that come back during the data phase fill the buffer.

One 32-bit configuration word sets the whole command: the opcode, the dummy count, the mode byte and whether it is sent, and whether the linear window is enabled at all. The window can be split across parallel flash buses, so the line base is divided by the bus count to form the flash address. Flash address bit 24 picks the upper of two devices, one chip-select line each. A requester holds its read request until it sees the one-cycle response strobe. A request that arrives during a refill simply waits.

Top module: `lin_flash_reader`

## Requirements
- R1: After reset, busy, tx_valid and rd_valid are low and both cs_n lines are high. The configuration word resets to 0x03A002EB, which leaves the linear window disabled.
- R2: Configuration word fields: opcode in bits 7:0, dummy byte count in bits 10:8, mode byte value in bits 23:16, mode byte send enable in bit 25, linear window enable in bit 31. A refill takes its fields from the word as it stands when the refill starts.
- R3: While bit 31 is clear, a read is answered with rd_data = 0 one cycle after it is accepted, and no flash traffic is started.
- R4: A refill sends these bytes in order: the opcode; three address bytes, most significant first; the mode byte if enabled; the configured number of 0x00 dummy bytes; then LINE_BYTES bytes of 0x00.
- R5: The flash address is the request address with its low log2(LINE_BYTES) bits cleared, divided by NUM_BUSES. Its bits 23:0 are the address bytes that are sent.
- R6: Flash address bit 24 set drives cs_n = 2'b01 for the whole frame; clear drives cs_n = 2'b10. Outside a frame cs_n = 2'b11, and at most one line is ever low.
- R7: Bytes received during the opcode, address, mode and dummy phases are dropped. The k-th byte received in the data phase is stored at line offset k.
- R8: A read hits when the line is valid and the word address lies between the line base and the base plus LINE_BYTES minus 4. A hit is answered one cycle later with no flash traffic. rd_data is little-endian: the byte at the lowest offset is in bits 7:0.
- R9: On a miss, busy stays high for the whole refill, and the request is then answered from the new line. rd_valid is a single-cycle pulse and is never high while busy is high.
- R10: A configuration write invalidates the line. A write made during a refill leaves that refilled line invalid, so the waiting request refills again using the new word.
- R11: Address bits 1:0 are ignored; every read returns the aligned 32-bit word.
- R12: tx_data holds steady while tx_valid is high and tx_ready is low. After a byte is accepted, tx_valid stays low until its rx_valid returns.
- R13: When a configuration write and a read request arrive in the same cycle, the write is taken first, so the read finds the line invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| rd_req | input | 1 | Read request, held until rd_valid |
| rd_addr | input | ADDR_W | Byte address in the linear window |
| rd_valid | output | 1 | Single-cycle response strobe |
| rd_data | output | 32 | Read word, little-endian |
| busy | output | 1 | Line refill in progress |
| tx_valid | output | 1 | Transmit byte offered to the serial engine |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serial engine accepts the transmit byte |
| rx_valid | input | 1 | Received byte strobe from the serial engine |
| rx_data | input | 8 | Received byte |
| cs_n | output | 2 | Active-low chip selects, bit 1 for the upper device |

## Verification
The bench builds the block with LINE_BYTES = 64, NUM_BUSES = 2 and ADDR_W = 26. The short line lets every word of each refilled line be swept, so all byte offsets, the hit boundary at base plus 60 and the first miss past it are covered. Two buses make the halving of the address visible in the transmitted address bytes, and 26 address bits let address bit 25 reach flash bit 24 and the upper chip select. Eight configuration words cover every dummy count, with the mode byte both sent and left out.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

  localparam logic [31:0] CFG_RESET = 32'h03A0_02EB;

  typedef struct packed {
    logic       mode_en;
    logic [7:0] mode_val;
    logic [2:0] dummy;
    logic [7:0] opcode;
  } lfr_frame_t;

  typedef enum logic [1:0] {E_IDLE, E_SEND, E_WAIT} lfr_eng_st_t;
  typedef enum logic [1:0] {S_IDLE, S_FILL, S_RESP} lfr_top_st_t;

  function automatic lfr_frame_t frame_of(input logic [31:0] w);
    lfr_frame_t f;
    f.mode_en  = w[25];
    f.mode_val = w[23:16];
    f.dummy    = w[10:8];
    f.opcode   = w[7:0];
    return f;
  endfunction

  // bytes before the data phase: opcode, 3 address bytes, mode, dummies
  function automatic logic [4:0] hdr_len(input lfr_frame_t f);
    return 5'd4 + {4'd0, f.mode_en} + {2'd0, f.dummy};
  endfunction

  function automatic logic [7:0] hdr_byte(input lfr_frame_t f,
                                          input logic [23:0] fa,
                                          input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:    b = f.opcode;
      4'd1:    b = fa[23:16];
      4'd2:    b = fa[15:8];
      4'd3:    b = fa[7:0];
      4'd4:    b = f.mode_en ? f.mode_val : 8'h00;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lfr_cfg_reg.sv
module lfr_cfg_reg
  import lfr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic        lin_en,
  output lfr_frame_t  frame
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{wdata[30:26], wdata[24], wdata[15:11]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_en <= CFG_RESET[31];
      frame  <= frame_of(CFG_RESET);
    end else if (wr) begin
      lin_en <= wdata[31];
      frame  <= frame_of(wdata);
    end
  end
endmodule

// File: rtl/lfr_frame_engine.sv
module lfr_frame_engine
  import lfr_pkg::*;
#(
  parameter int LINE_BYTES = 1024,
  parameter int OFF_W      = $clog2(LINE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  lfr_frame_t       frame,
  input  logic [23:0]      fa,
  output logic             active,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             wr_en,
  output logic [OFF_W-1:0] wr_idx,
  output logic [7:0]       wr_byte,
  output logic             done
);
  localparam int IDX_W = $clog2(LINE_BYTES + 16);

  lfr_eng_st_t      st;
  logic [IDX_W-1:0] idx;
  lfr_frame_t       frame_q;
  logic [23:0]      fa_q;
  logic [IDX_W-1:0] hl_ext;
  logic [IDX_W-1:0] data_idx;
  logic             in_hdr;
  logic             last_byte;
  logic             rx_take;
  logic             unused_idx_bits;

  assign hl_ext    = IDX_W'(hdr_len(frame_q));
  assign in_hdr    = idx < hl_ext;
  assign last_byte = idx == (hl_ext + IDX_W'(LINE_BYTES - 1));
  assign data_idx  = idx - hl_ext;
  assign rx_take   = (st == E_WAIT) && rx_valid;

  assign active    = st != E_IDLE;
  assign tx_valid  = st == E_SEND;
  assign tx_data   = in_hdr ? hdr_byte(frame_q, fa_q, idx[3:0]) : 8'h00;
  assign wr_en     = rx_take && !in_hdr;
  assign wr_idx    = data_idx[OFF_W-1:0];
  assign wr_byte   = rx_data;
  assign done      = rx_take && last_byte;
  assign unused_idx_bits = ^data_idx[IDX_W-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      idx     <= '0;
      frame_q <= '0;
      fa_q    <= '0;
    end else begin
      case (st)
        E_IDLE: if (start) begin
          st      <= E_SEND;
          idx     <= '0;
          frame_q <= frame;
          fa_q    <= fa;
        end
        E_SEND: if (tx_ready) st <= E_WAIT;
        E_WAIT: if (rx_valid) begin
          if (last_byte) begin
            st <= E_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= E_SEND;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lfr_line_buf.sv
module lfr_line_buf #(
  parameter int LINE_BYTES = 1024,
  parameter int OFF_W      = $clog2(LINE_BYTES),
  parameter int WIDX_W     = OFF_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_idx,
  input  logic [7:0]        wr_byte,
  input  logic              rd_en,
  input  logic [WIDX_W-1:0] rd_widx,
  output logic [31:0]       rd_word
);
  logic [7:0] mem [LINE_BYTES];
  logic [31:0] word_c;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_byte;
  end

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign word_c[8*b +: 8] = mem[{rd_widx, 2'(b)}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_word <= '0;
    else if (rd_en) rd_word <= word_c;
  end
endmodule

// File: rtl/lin_flash_reader.sv
module lin_flash_reader
  import lfr_pkg::*;
#(
  parameter int LINE_BYTES = 1024,
  parameter int NUM_BUSES  = 2,
  parameter int ADDR_W     = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              busy,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic [1:0]        cs_n
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BUS_SH = $clog2(NUM_BUSES);
  localparam int WIDX_W = OFF_W - 2;

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic in_line(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] b);
    logic [ADDR_W:0] hi;
    hi = {1'b0, b} + (ADDR_W + 1)'(LINE_BYTES - 4);
    return ({1'b0, a} >= {1'b0, b}) && ({1'b0, a} <= hi);
  endfunction

  lfr_top_st_t       st;
  logic              lin_en;
  lfr_frame_t        frame;
  logic [ADDR_W-1:0] req_w;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       fa32;
  logic              line_valid;
  logic              stale;
  logic              upper_q;
  logic              zero_q;
  logic              req_take;
  logic              hit;
  logic              hit_take;
  logic              off_take;
  logic              fill_start;
  logic              eng_active;
  logic              eng_done;
  logic              buf_wr;
  logic [OFF_W-1:0]  buf_idx;
  logic [7:0]        buf_byte;
  logic [31:0]       buf_word;
  logic              unused_addr_bits;

  assign req_w      = {rd_addr[ADDR_W-1:2], 2'b00};
  assign fa32       = 32'(line_base(req_w)) >> BUS_SH;
  assign req_take   = (st == S_IDLE) && rd_req && !cfg_wr;
  assign hit        = line_valid && in_line(req_w, base_q);
  assign off_take   = req_take && !lin_en;
  assign hit_take   = req_take && lin_en && hit;
  assign fill_start = req_take && lin_en && !hit;
  assign unused_addr_bits = ^{rd_addr[1:0], fa32[31:25]};

  lfr_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .wdata  (cfg_wdata),
    .lin_en (lin_en),
    .frame  (frame)
  );

  lfr_frame_engine #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (fill_start),
    .frame    (frame),
    .fa       (fa32[23:0]),
    .active   (eng_active),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .wr_en    (buf_wr),
    .wr_idx   (buf_idx),
    .wr_byte  (buf_byte),
    .done     (eng_done)
  );

  lfr_line_buf #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W), .WIDX_W(WIDX_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (buf_wr),
    .wr_idx  (buf_idx),
    .wr_byte (buf_byte),
    .rd_en   (hit_take),
    .rd_widx (req_w[OFF_W-1:2]),
    .rd_word (buf_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      upper_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (off_take || hit_take) begin
            zero_q <= off_take;
            st     <= S_RESP;
          end else if (fill_start) begin
            base_q  <= line_base(req_w);
            upper_q <= fa32[24];
            st      <= S_FILL;
          end
        end
        S_FILL:  if (eng_done) st <= S_IDLE;
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_valid <= 1'b0;
      stale      <= 1'b0;
    end else begin
      if (cfg_wr)          line_valid <= 1'b0;
      else if (fill_start) line_valid <= 1'b0;
      else if (eng_done)   line_valid <= !stale;

      if (fill_start)                   stale <= 1'b0;
      else if (cfg_wr && st == S_FILL)  stale <= 1'b1;
    end
  end

  assign rd_valid = st == S_RESP;
  assign rd_data  = zero_q ? 32'h0 : buf_word;
  assign busy     = st == S_FILL;
  assign cs_n     = !eng_active ? 2'b11 : (upper_q ? 2'b01 : 2'b10);

endmodule

// File: rtl/lfr_chk.sv
module lfr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       rd_valid,
  input logic       busy,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic [1:0] cs_n,
  input logic       line_valid,
  input logic       eng_done
);
  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R6
  tx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (cs_n != 2'b11));

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R12
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);

  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R9
  busy_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_valid);

  // R9
  done_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> busy);

  // R10
  cfg_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !line_valid);
endmodule

bind lin_flash_reader lfr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .rd_valid   (rd_valid),
  .busy       (busy),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .tx_ready   (tx_ready),
  .cs_n       (cs_n),
  .line_valid (line_valid),
  .eng_done   (eng_done)
);

// File: tb/tb_lin_flash_reader.sv
module tb_lin_flash_reader;
  localparam int LINE = 64;
  localparam int NB   = 2;
  localparam int AW   = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic          busy;
  logic          tx_valid;
  logic [7:0]    tx_data;
  logic          tx_ready = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic [1:0]    cs_n;

  lin_flash_reader #(.LINE_BYTES(LINE), .NUM_BUSES(NB), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .cs_n(cs_n)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // ---------------- behavioural flash model ----------------
  int         tb_hdr = 4;
  int         nb = 0;
  int         frames = 0;
  int         frame_len = 0;
  int         bad_tx = 0;
  int         dly = 0;
  int         cyc = 0;
  logic [1:0] frame_cs = 2'b11;
  logic [7:0] hdr [16];

  function automatic logic [7:0] pat(input logic up, input logic [23:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ (up ? 8'h3C : 8'h00) ^ 8'h11;
  endfunction

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    tx_ready <= (cyc % 5) != 4;
    rx_valid <= 1'b0;
    if (dly > 0) begin
      dly <= dly - 1;
      if (dly == 1) rx_valid <= 1'b1;
    end
    if (cs_n == 2'b11) begin
      if (nb != 0) frame_len <= nb;
      nb <= 0;
    end else if (tx_valid && tx_ready) begin
      if (nb == 0) begin
        frames   <= frames + 1;
        frame_cs <= cs_n;
      end
      if (nb < 16) hdr[nb] <= tx_data;
      if (nb >= tb_hdr && tx_data != 8'h00) bad_tx <= bad_tx + 1;
      if (nb < tb_hdr) rx_data <= 8'hA5;
      else rx_data <= pat(!cs_n[1], {hdr[1], hdr[2], hdr[3]} + 24'(nb - tb_hdr));
      nb  <= nb + 1;
      dly <= 2;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] flash_of(input logic [AW-1:0] a);
    logic [31:0] base;
    base = 32'(a) & ~32'(LINE - 1);
    return base / NB;
  endfunction

  function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
    logic [31:0] f;
    logic [31:0] w;
    int off;
    f   = flash_of(a);
    off = int'(a % LINE) & ~3;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = pat(f[24], f[23:0] + 24'(off + i));
    return w;
  endfunction

  logic busy_seen;

  task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d, output int lat);
    @(negedge clk);
    rd_req    = 1'b1;
    rd_addr   = a;
    lat       = 0;
    busy_seen = 1'b0;
    do begin
      @(negedge clk);
      lat++;
      if (busy) busy_seen = 1'b1;
    end while (!rd_valid);
    d      = rd_data;
    rd_req = 1'b0;
  endtask

  task automatic set_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = w;
    tb_hdr    = 4 + int'(w[25]) + int'(w[10:8]);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic check_frame(input logic [31:0] w, input logic [AW-1:0] a);
    logic [31:0] f;
    int h;
    f = flash_of(a);
    h = 4 + int'(w[25]) + int'(w[10:8]);
    check("R4 opcode byte", 32'(hdr[0]), 32'(w[7:0]));
    check("R5 address byte 23:16", 32'(hdr[1]), 32'(f[23:16]));
    check("R5 address byte 15:8", 32'(hdr[2]), 32'(f[15:8]));
    check("R5 address byte 7:0", 32'(hdr[3]), 32'(f[7:0]));
    if (w[25]) check("R2 mode byte", 32'(hdr[4]), 32'(w[23:16]));
    for (int i = 0; i < int'(w[10:8]); i++)
      check("R4 dummy byte zero", 32'(hdr[4 + int'(w[25]) + i]), 32'h0);
    check("R4 frame length", 32'(frame_len), 32'(h + LINE));
    check("R6 chip select", 32'(frame_cs), f[24] ? 32'h1 : 32'h2);
    check("R12 data clocks are zero", 32'(bad_tx), 32'h0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] d;
    logic [31:0] w;
    logic [AW-1:0] a;
    logic [AW-1:0] base;
    int lat;
    int f0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy low", 32'(busy), 32'h0);
    check("R1 cs_n idle", 32'(cs_n), 32'h3);
    check("R1 tx_valid low", 32'(tx_valid), 32'h0);
    check("R1 rd_valid low", 32'(rd_valid), 32'h0);

    // reset word leaves the window disabled
    f0 = frames;
    do_read(26'h0000104, d, lat);
    check("R3 disabled data", d, 32'h0);
    check("R3 disabled latency", 32'(lat), 32'h1);
    check("R1 R3 no frame while disabled", 32'(frames - f0), 32'h0);

    // sweep of configuration words
    for (int c = 0; c < 8; c++) begin
      w = 32'h8000_0000 | (32'(c & 1) << 25) | (32'(8'hC0 + c) << 16)
        | (32'(c) << 8) | 32'(8'h0B + 8'(c * 16));
      set_cfg(w);
      a = AW'(26'h0040000 + c * 26'h0013A40);
      if (c >= 5) a = a | 26'h2000000;
      base = a & ~AW'(LINE - 1);
      a = base + AW'((c * 4) % LINE) + 2'b11;
      f0 = frames;
      do_read(a, d, lat);
      check("R9 miss refills once", 32'(frames - f0), 32'h1);
      check("R9 busy during refill", 32'(busy_seen), 32'h1);
      check("R7 R11 miss data", d, exp_word(a));
      check_frame(w, a);
      for (int k = 0; k < LINE / 4; k++) begin
        f0 = frames;
        do_read(base + AW'(k * 4) + AW'(k & 3), d, lat);
        check("R8 hit data little-endian", d, exp_word(base + AW'(k * 4)));
        check("R8 hit latency", 32'(lat), 32'h1);
        check("R8 hit no frame", 32'(frames - f0), 32'h0);
      end
      f0 = frames;
      do_read(base + AW'(LINE), d, lat);
      check("R8 just past line misses", 32'(frames - f0), 32'h1);
      check("R7 next line data", d, exp_word(base + AW'(LINE)));
    end

    // configuration write invalidates the line
    a = 26'h0123440;
    do_read(a, d, lat);
    f0 = frames;
    do_read(a, d, lat);
    check("R8 repeat hits", 32'(frames - f0), 32'h0);
    set_cfg(w);
    f0 = frames;
    do_read(a, d, lat);
    check("R10 refill after write", 32'(frames - f0), 32'h1);
    check("R10 data after write", d, exp_word(a));

    // write and request in the same cycle
    f0 = frames;
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = w;
    rd_req = 1'b1;
    rd_addr = a;
    @(negedge clk);
    cfg_wr = 1'b0;
    while (!rd_valid) @(negedge clk);
    d = rd_data;
    rd_req = 1'b0;
    check("R13 write first forces refill", 32'(frames - f0), 32'h1);
    check("R13 data", d, exp_word(a));

    // write during a refill
    a = 26'h2345680;
    f0 = frames;
    fork
      do_read(a, d, lat);
      begin
        repeat (40) @(negedge clk);
        set_cfg((w & 32'hFFFF_FF00) | 32'h0000_006B);
      end
    join
    check("R10 write mid refill refills again", 32'(frames - f0), 32'h2);
    check("R10 data after second refill", d, exp_word(a));
    check("R2 new opcode used", 32'(hdr[0]), 32'h6B);
    f0 = frames;
    do_read(a, d, lat);
    check("R10 second line valid", 32'(frames - f0), 32'h0);

    // disable the window again
    set_cfg(w & 32'h7FFF_FFFF);
    f0 = frames;
    do_read(a, d, lat);
    check("R3 disabled after enable", d, 32'h0);
    check("R3 disabled no frame", 32'(frames - f0), 32'h0);
    @(negedge clk);
    check("R6 cs_n idle at end", 32'(cs_n), 32'h3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule